// File: doc/BRIEF.md
# Source-Synchronous DMA Burst Host Engine

This block is the host end of a double-edge DMA data burst on a parallel disk interface. Three legacy control pins change meaning with the transfer direction. In a read burst the device toggles a strobe and the host captures one 16-bit word on each transition, rising or falling. In that direction the host drives an active-low ready line so it can insert wait states. In a write burst the host toggles the strobe and puts a new word on the bus for each transition, and the device's active-low ready line can hold it back. In both directions a separate host-driven stop line ends a burst, or acknowledges an end that the device asks for. The device asks for an end by dropping its DMA request line. Every word that moves is folded into a CRC-16, which is checked or sent when the burst ends.

On the internal side, received words come out as one-cycle valid pulses, and words to send are pulled from a valid/pop source. The bus-master logic reports how many free entries its receive buffer has, and it starts and stops bursts with single-cycle pulses. When the mode-enable input is low, the three pins pass the legacy programmed-I/O strobes straight through, and no burst can start.

Top module: `ssdma_host`

## Requirements
- R1: While `modeEn` is low, `wrStbPin` follows `pioWrStbN`, `rdStbPin` follows `pioRdStbN`, `pioRdy` follows `rdyPin`, and a start pulse does not make `busy` rise.
- R2: After reset the engine is idle: `busy` is low, `wrStbPin` is low and `rdStbPin` is high. A burst starts only when `modeEn` is high, `dmaReqPin` is high and `startRd` or `startWr` is pulsed. If both are pulsed, the burst is a write. In a read burst with more than PAUSE_AT free entries, `rdStbPin` is driven low to show the host is ready, and `wrStbPin` stays low.
- R3: In a read burst, each transition of `rdyPin`, whether rising or falling, delivers the word on `ddIn` at that time as one `rxData` word with a one-cycle `rxValid`. Words arrive in the order they were sent.
- R4: In a read burst, when `rxSpace` is at or below PAUSE_AT, `rdStbPin` is high on the next cycle. Strobe transitions that arrive after that are still captured.
- R5: In a write burst, `rdStbPin` is high in the cycle `ddOe` rises. Each `txReady` pop puts the next `txData` word on `ddOut` one clock before the `rdStbPin` transition that carries it.
- R6: While `rdyPin` is held high (device not ready) during a write burst, `rdStbPin` stops toggling within four clocks and stays stable.
- R7: When a write burst ends after an odd number of strobe transitions, the engine sends one extra word of value 0x0000. The strobe is therefore high when `wrStbPin` rises.
- R8: A `stopReq` pulse raises `wrStbPin` while `dmaReqPin` is still high, and the burst waits until the device drops `dmaReqPin`. If the device drops `dmaReqPin` first, `wrStbPin` rises as the acknowledgement. A burst never ends without `wrStbPin` high in its last cycle.
- R9: The CRC uses polynomial 0x1021. It is fed 16 bits per word, MSB first, and seeded with 0x4ABA at each start. It covers every word moved, including the extra word. In a write burst the result is driven on `ddOut` (with `ddOe` high) from termination until `done`. In a read burst, the word the device holds on `ddIn` during termination is compared with the result, and `crcErr` is set on a mismatch and cleared on a match.
- R10: The end of a burst is marked by `done` high for exactly one cycle, and `busy` falls on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rstN | input | 1 | Active-low reset |
| modeEn | input | 1 | Burst mode enable for the selected device |
| startRd | input | 1 | Start pulse for a read burst |
| startWr | input | 1 | Start pulse for a write burst |
| stopReq | input | 1 | Pulse that asks the host to end the burst |
| rxSpace | input | SPW | Free entries in the receive buffer |
| rxValid | output | 1 | Received word valid (one cycle) |
| rxData | output | 16 | Received word |
| txValid | input | 1 | A word to send is available |
| txData | input | 16 | Word to send |
| txReady | output | 1 | Pops the word to send |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle end-of-burst pulse |
| crcErr | output | 1 | Read CRC mismatch in the last burst |
| pioWrStbN | input | 1 | Legacy write strobe from PIO logic |
| pioRdStbN | input | 1 | Legacy read strobe from PIO logic |
| pioRdy | output | 1 | Legacy ready returned to PIO logic |
| wrStbPin | output | 1 | Legacy write strobe pin, used as stop in burst mode |
| rdStbPin | output | 1 | Legacy read strobe pin: ready (read) or strobe (write) |
| rdyPin | input | 1 | Legacy ready pin: strobe (read) or ready (write) |
| dmaReqPin | input | 1 | Device DMA request |
| ddIn | input | 16 | Data bus input |
| ddOut | output | 16 | Data bus output |
| ddOe | output | 1 | Data bus output enable |

## Verification
The hardest case to reach from the ports is a write burst that ends on an odd transition count after a device pause. Here the extra word and the CRC interact: the pad has to be folded into the CRC, and the strobe has to return high before stop is raised. To get there, the bench holds the device ready line high mid-burst, then releases it. It supplies five words and asks for a stop only after the fifth transition has been seen. It then checks the sixth transition carrying 0x0000 and the CRC driven on the bus. The read side uses two bursts: one where the device ends the burst with the correct CRC, and one where the host asks for the stop and the device answers with a corrupted CRC.

// File: rtl/ssdma_pkg.sv
package ssdma_pkg;
  localparam int WORD_W = 16;
  localparam logic [15:0] CRC_SEED = 16'h4ABA;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_READ, ST_WRITE, ST_PAUSE, ST_STOPREQ, ST_TERM, ST_CRC
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic seed;
    logic capRd;
    logic loadTx;
    logic loadPad;
    logic toggle;
    logic crcOut;
    logic check;
  } dpCtl_t;

  function automatic logic [15:0] crcStep(input logic [15:0] c, input logic [WORD_W-1:0] d);
    logic [15:0] r;
    r = c;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      r = {r[14:0], 1'b0} ^ ((r[15] ^ d[i]) ? CRC_POLY : 16'h0000);
    end
    return r;
  endfunction
endpackage

// File: rtl/ssdma_ctrl.sv
module ssdma_ctrl import ssdma_pkg::*; #(
  parameter int SPW      = 4,
  parameter int PAUSE_AT = 2,
  parameter int STB_HOLD = 2,
  parameter int TERM_CYC = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           modeEn,
  input  logic           startRd,
  input  logic           startWr,
  input  logic           stopReq,
  input  logic           txValid,
  input  logic [SPW-1:0] rxSpace,
  input  logic           rdEdge,
  input  logic           devRdy,
  input  logic           devReq,
  input  logic           stbHigh,
  output dpCtl_t         ctl,
  output logic           dirWr,
  output logic           busy,
  output logic           done,
  output logic           stopOn,
  output logic           readyN,
  output logic           txReady
);
  localparam int HW = $clog2(STB_HOLD + 1);
  localparam int TW = $clog2(TERM_CYC + 1);

  state_e        state, nxt;
  logic          hostStop, pend;
  logic [HW-1:0] gap;
  logic [TW-1:0] termCnt;
  logic          roomOk, wrOk, endReq;

  assign roomOk = rxSpace > SPW'(PAUSE_AT);
  assign wrOk   = !pend && (gap == '0) && devRdy;
  assign endReq = hostStop || !devReq;

  always_comb begin
    nxt = state;
    ctl = '0;
    ctl.toggle = pend;
    unique case (state)
      ST_IDLE:
        if (modeEn && devReq && (startRd || startWr)) begin
          nxt = ST_START;
          ctl.seed = 1'b1;
        end
      ST_START:
        if (dirWr) nxt = devRdy ? ST_WRITE : ST_PAUSE;
        else       nxt = roomOk ? ST_READ : ST_PAUSE;
      ST_READ, ST_PAUSE, ST_WRITE:
        if (!dirWr) begin
          ctl.capRd = rdEdge;
          if (!devReq)       nxt = ST_TERM;
          else if (hostStop) nxt = ST_STOPREQ;
          else               nxt = roomOk ? ST_READ : ST_PAUSE;
        end else begin
          nxt = devRdy ? ST_WRITE : ST_PAUSE;
          if (endReq) begin
            if (!pend && stbHigh)       nxt = (hostStop && devReq) ? ST_STOPREQ : ST_TERM;
            else if (wrOk && !stbHigh)  ctl.loadPad = 1'b1;
          end else if (wrOk && txValid) begin
            ctl.loadTx = 1'b1;
          end
        end
      ST_STOPREQ: begin
        ctl.capRd = !dirWr && rdEdge;
        if (!devReq) nxt = ST_TERM;
      end
      ST_TERM: begin
        ctl.capRd  = !dirWr && rdEdge;
        ctl.crcOut = dirWr;
        if (termCnt == '0) nxt = ST_CRC;
      end
      ST_CRC: begin
        ctl.check = !dirWr;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dirWr    <= 1'b0;
      hostStop <= 1'b0;
      pend     <= 1'b0;
      gap      <= '0;
      termCnt  <= TW'(TERM_CYC);
      readyN   <= 1'b1;
    end else begin
      state    <= nxt;
      if (ctl.seed) dirWr <= startWr;
      hostStop <= (state == ST_IDLE) ? 1'b0 : (hostStop || stopReq);
      pend     <= ctl.loadTx || ctl.loadPad;
      if (pend)             gap <= HW'(STB_HOLD);
      else if (gap != '0)   gap <= gap - 1'b1;
      termCnt  <= (state == ST_TERM) ? termCnt - 1'b1 : TW'(TERM_CYC);
      readyN   <= (nxt != ST_READ);
    end
  end

  assign busy    = (state != ST_IDLE);
  assign done    = (state == ST_CRC);
  assign stopOn  = (state == ST_STOPREQ) || (state == ST_TERM) || (state == ST_CRC);
  assign txReady = ctl.loadTx;
endmodule

// File: rtl/ssdma_dp.sv
module ssdma_dp import ssdma_pkg::*; (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              rdyPin,
  input  logic              dmaReqPin,
  input  logic [WORD_W-1:0] ddIn,
  input  logic [WORD_W-1:0] txData,
  output logic              rdEdge,
  output logic              devRdy,
  output logic              devReq,
  output logic              stb,
  output logic [WORD_W-1:0] ddOut,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData,
  output logic              crcErr
);
  logic [1:0]        rdySync, reqSync;
  logic              rdyPrev;
  logic [WORD_W-1:0] d1, d2;
  logic [15:0]       crc;

  // data bus is delayed by the same two stages as the strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdySync <= '0;
      reqSync <= '0;
      rdyPrev <= 1'b0;
      d1      <= '0;
      d2      <= '0;
    end else begin
      rdySync <= {rdySync[0], rdyPin};
      reqSync <= {reqSync[0], dmaReqPin};
      rdyPrev <= rdySync[1];
      d1      <= ddIn;
      d2      <= d1;
    end
  end

  assign rdEdge = rdySync[1] ^ rdyPrev;
  assign devRdy = !rdySync[1];
  assign devReq = reqSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      crc     <= CRC_SEED;
      stb     <= 1'b1;
      ddOut   <= '0;
      rxValid <= 1'b0;
      rxData  <= '0;
      crcErr  <= 1'b0;
    end else begin
      if (ctl.seed)         crc <= CRC_SEED;
      else if (ctl.capRd)   crc <= crcStep(crc, d2);
      else if (ctl.loadTx)  crc <= crcStep(crc, txData);
      else if (ctl.loadPad) crc <= crcStep(crc, '0);
      if (ctl.loadTx)       ddOut <= txData;
      else if (ctl.loadPad) ddOut <= '0;
      else if (ctl.crcOut)  ddOut <= crc;
      if (ctl.toggle) stb <= !stb;
      rxValid <= ctl.capRd;
      if (ctl.capRd) rxData <= d2;
      if (ctl.seed)       crcErr <= 1'b0;
      else if (ctl.check) crcErr <= (d2 != crc);
    end
  end
endmodule

// File: rtl/ssdma_host.sv
module ssdma_host import ssdma_pkg::*; #(
  parameter int SPW      = 4,
  parameter int PAUSE_AT = 2,
  parameter int STB_HOLD = 2,
  parameter int TERM_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeEn,
  input  logic              startRd,
  input  logic              startWr,
  input  logic              stopReq,
  input  logic [SPW-1:0]    rxSpace,
  output logic              rxValid,
  output logic [WORD_W-1:0] rxData,
  input  logic              txValid,
  input  logic [WORD_W-1:0] txData,
  output logic              txReady,
  output logic              busy,
  output logic              done,
  output logic              crcErr,
  input  logic              pioWrStbN,
  input  logic              pioRdStbN,
  output logic              pioRdy,
  output logic              wrStbPin,
  output logic              rdStbPin,
  input  logic              rdyPin,
  input  logic              dmaReqPin,
  input  logic [WORD_W-1:0] ddIn,
  output logic [WORD_W-1:0] ddOut,
  output logic              ddOe
);
  dpCtl_t ctl;
  logic   rdEdge, devRdy, devReq, stb, dirWr, stopOn, readyN;

  ssdma_ctrl #(.SPW(SPW), .PAUSE_AT(PAUSE_AT), .STB_HOLD(STB_HOLD), .TERM_CYC(TERM_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .startRd(startRd), .startWr(startWr),
    .stopReq(stopReq), .txValid(txValid), .rxSpace(rxSpace), .rdEdge(rdEdge),
    .devRdy(devRdy), .devReq(devReq), .stbHigh(stb), .ctl(ctl), .dirWr(dirWr),
    .busy(busy), .done(done), .stopOn(stopOn), .readyN(readyN), .txReady(txReady)
  );

  ssdma_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rdyPin(rdyPin), .dmaReqPin(dmaReqPin),
    .ddIn(ddIn), .txData(txData), .rdEdge(rdEdge), .devRdy(devRdy), .devReq(devReq),
    .stb(stb), .ddOut(ddOut), .rxValid(rxValid), .rxData(rxData), .crcErr(crcErr)
  );

  // pin remapping by mode and direction
  assign wrStbPin = modeEn ? stopOn : pioWrStbN;
  assign rdStbPin = modeEn ? (dirWr ? stb : readyN) : pioRdStbN;
  assign pioRdy   = modeEn ? 1'b1 : rdyPin;
  assign ddOe     = busy && dirWr;
endmodule

// File: rtl/ssdma_host_chk.sv
module ssdma_host_chk #(
  parameter int SPW      = 4,
  parameter int PAUSE_AT = 2
) (
  input logic           clk,
  input logic           rstN,
  input logic           modeEn,
  input logic           busy,
  input logic           dirWr,
  input logic [SPW-1:0] rxSpace,
  input logic           rdStbPin,
  input logic           wrStbPin,
  input logic           rdyPin,
  input logic           ddOe,
  input logic           rxValid
);
  p_no_burst_legacy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!modeEn && !busy) |=> !busy);

  p_single_capture_r3: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  p_ready_pause_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeEn && busy && !dirWr && rxSpace <= SPW'(PAUSE_AT)) |=> (!modeEn || rdStbPin));

  p_start_high_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ddOe) |-> rdStbPin);

  p_hold_unready_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ddOe && $past(ddOe) && rdyPin && $past(rdyPin) && $past(rdyPin, 2) &&
     $past(rdyPin, 3) && $past(rdyPin, 4)) |-> $stable(rdStbPin));

  p_stop_before_end_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(busy) && modeEn) |-> $past(wrStbPin));
endmodule

bind ssdma_host ssdma_host_chk #(.SPW(SPW), .PAUSE_AT(PAUSE_AT)) u_chk (
  .clk(clk), .rstN(rstN), .modeEn(modeEn), .busy(busy), .dirWr(dirWr),
  .rxSpace(rxSpace), .rdStbPin(rdStbPin), .wrStbPin(wrStbPin), .rdyPin(rdyPin),
  .ddOe(ddOe), .rxValid(rxValid)
);

// File: tb/ssdma_host_tb.sv
module ssdma_host_tb;
  localparam int SPW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, modeEn, startRd, startWr, stopReq, txValid, txReady;
  logic busy, done, crcErr, pioWrStbN, pioRdStbN, pioRdy;
  logic wrStbPin, rdStbPin, rdyPin, dmaReqPin, ddOe, rxValid;
  logic [SPW-1:0] rxSpace;
  logic [15:0] rxData, txData, ddIn, ddOut;

  ssdma_host u_dut (
    .clk(clk), .rstN(rstN), .modeEn(modeEn), .startRd(startRd), .startWr(startWr),
    .stopReq(stopReq), .rxSpace(rxSpace), .rxValid(rxValid), .rxData(rxData),
    .txValid(txValid), .txData(txData), .txReady(txReady), .busy(busy), .done(done),
    .crcErr(crcErr), .pioWrStbN(pioWrStbN), .pioRdStbN(pioRdStbN), .pioRdy(pioRdy),
    .wrStbPin(wrStbPin), .rdStbPin(rdStbPin), .rdyPin(rdyPin), .dmaReqPin(dmaReqPin),
    .ddIn(ddIn), .ddOut(ddOut), .ddOe(ddOe)
  );

  int checks = 0;
  int fails = 0;
  logic [15:0] expQ[$];
  logic [15:0] crcM;
  logic [15:0] txArr[0:15];
  int txIdx = 0;
  int txN = 0;
  int wrEdges = 0;
  logic prevStb = 1'b1;

  function automatic logic [15:0] crcNext(input logic [15:0] c, input logic [15:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 15; i >= 0; i--) begin
      logic fb;
      fb = r[15] ^ d[i];
      r = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // word source for writes
  assign txValid = txIdx < txN;
  assign txData  = txValid ? txArr[txIdx] : 16'h0000;
  always @(posedge clk) if (txReady && txValid) txIdx <= txIdx + 1;

  // scoreboard monitor: read words and write strobe transitions
  always @(negedge clk) begin
    if (rxValid) begin
      if (expQ.size() == 0) chk("R3 unexpected read word", rxData, 32'hFFFF_FFFF);
      else chk("R3 read word", rxData, expQ.pop_front());
    end
    if (ddOe && rdStbPin !== prevStb) begin
      wrEdges++;
      if (expQ.size() == 0) chk("R5 R7 unexpected write word", ddOut, 32'hFFFF_FFFF);
      else chk("R5 R7 write word", ddOut, expQ.pop_front());
    end
    prevStb = rdStbPin;
  end

  task automatic devSend(input logic [15:0] w);
    ddIn = w;
    tick(1);
    expQ.push_back(w);
    crcM = crcNext(crcM, w);
    rdyPin = ~rdyPin;
    tick(3);
  endtask

  task automatic pulseStart(input bit wr);
    if (wr) startWr = 1'b1; else startRd = 1'b1;
    tick(1);
    startWr = 1'b0;
    startRd = 1'b0;
  endtask

  task automatic waitDone(input string tag);
    for (int i = 0; i < 60 && !done; i++) tick(1);
    chk(tag, done, 1'b1);
  endtask

  task automatic waitEdges(input int n, input int idx);
    for (int i = 0; i < 200 && (wrEdges < n || txIdx < idx); i++) tick(1);
    chk("R5 write progress", wrEdges, n);
  endtask

  task automatic queueWord(input logic [15:0] w);
    txArr[txN] = w;
    expQ.push_back(w);
    crcM = crcNext(crcM, w);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; modeEn = 1'b1; startRd = 1'b0; startWr = 1'b0; stopReq = 1'b0;
    rxSpace = 4'd8; pioWrStbN = 1'b1; pioRdStbN = 1'b1; rdyPin = 1'b0;
    dmaReqPin = 1'b0; ddIn = 16'h0000; crcM = 16'h4ABA;
    tick(3);
    rstN = 1'b1;
    tick(2);
    chk("R2 reset busy", busy, 0);
    chk("R2 reset ddOe", ddOe, 0);
    chk("R2 reset stop pin", wrStbPin, 0);
    chk("R2 reset ready pin", rdStbPin, 1);
    chk("R2 reset rxValid", rxValid, 0);

    // R1 legacy pass-through
    modeEn = 1'b0; pioWrStbN = 1'b0; pioRdStbN = 1'b1; rdyPin = 1'b1;
    tick(1);
    chk("R1 wr pin legacy", wrStbPin, 0);
    chk("R1 rd pin legacy", rdStbPin, 1);
    chk("R1 rdy legacy", pioRdy, 1);
    pioWrStbN = 1'b1; pioRdStbN = 1'b0; rdyPin = 1'b0;
    tick(1);
    chk("R1 wr pin legacy b", wrStbPin, 1);
    chk("R1 rd pin legacy b", rdStbPin, 0);
    chk("R1 rdy legacy b", pioRdy, 0);
    dmaReqPin = 1'b1;
    tick(4);
    pulseStart(1'b0);
    tick(4);
    chk("R1 no burst when disabled", busy, 0);
    modeEn = 1'b1; pioRdStbN = 1'b1;
    tick(2);

    // read burst, device ends it with a correct CRC
    crcM = 16'h4ABA;
    pulseStart(1'b0);
    tick(3);
    chk("R2 read busy", busy, 1);
    chk("R2 ready driven low", rdStbPin, 0);
    chk("R2 stop low in burst", wrStbPin, 0);
    devSend(16'h1111); devSend(16'h2222); devSend(16'h3333); devSend(16'h4444);
    rxSpace = 4'd2;
    tick(2);
    chk("R4 ready deasserted", rdStbPin, 1);
    devSend(16'h5A5A); devSend(16'hA5A5); devSend(16'h0001);
    tick(4);
    chk("R4 late words captured", expQ.size(), 0);
    rxSpace = 4'd8;
    tick(2);
    chk("R4 ready again", rdStbPin, 0);
    ddIn = crcM;
    dmaReqPin = 1'b0;
    tick(4);
    chk("R8 device stop ack read", wrStbPin, 1);
    waitDone("R10 read done");
    tick(1);
    chk("R10 done single cycle", done, 0);
    chk("R10 busy falls", busy, 0);
    chk("R9 read crc match", crcErr, 0);

    // read burst, host stop, bad CRC
    dmaReqPin = 1'b1;
    tick(4);
    crcM = 16'h4ABA;
    pulseStart(1'b0);
    tick(3);
    devSend(16'hABCD); devSend(16'h0F0F);
    stopReq = 1'b1; tick(1); stopReq = 1'b0;
    tick(4);
    chk("R8 host stop asserted", wrStbPin, 1);
    tick(5);
    chk("R8 waits for device", busy, 1);
    ddIn = crcM ^ 16'h0001;
    dmaReqPin = 1'b0;
    waitDone("R10 read b done");
    tick(1);
    chk("R9 read crc mismatch", crcErr, 1);

    // write burst with pause, odd count, host stop
    rdyPin = 1'b0;
    dmaReqPin = 1'b1;
    tick(4);
    crcM = 16'h4ABA;
    for (int k = 0; k < 5; k++) begin
      queueWord(16'hA001 + 16'(k));
      txN = txN + 1;
    end
    expQ.push_back(16'h0000);
    crcM = crcNext(crcM, 16'h0000);
    startWr = 1'b1;
    tick(1);
    startWr = 1'b0;
    chk("R5 write start ddOe", ddOe, 1);
    chk("R5 strobe high at start", rdStbPin, 1);
    waitEdges(2, 0);
    rdyPin = 1'b1;
    tick(6);
    begin
      int c;
      c = wrEdges;
      tick(20);
      chk("R6 no toggle while not ready", wrEdges, c);
    end
    rdyPin = 1'b0;
    waitEdges(5, 5);
    stopReq = 1'b1; tick(1); stopReq = 1'b0;
    for (int i = 0; i < 60 && !wrStbPin; i++) tick(1);
    chk("R8 write host stop", wrStbPin, 1);
    chk("R7 pad edge", wrEdges, 6);
    chk("R7 strobe high at stop", rdStbPin, 1);
    dmaReqPin = 1'b0;
    waitDone("R10 write done");
    chk("R9 write crc", ddOut, crcM);
    chk("R9 write crc driven", ddOe, 1);
    tick(1);
    chk("R10 write busy falls", busy, 0);
    chk("R7 queue empty", expQ.size(), 0);

    // write burst, even count, device stop
    dmaReqPin = 1'b1;
    tick(4);
    crcM = 16'h4ABA;
    queueWord(16'hB006); txN = txN + 1;
    queueWord(16'hB007); txN = txN + 1;
    pulseStart(1'b1);
    waitEdges(8, 7);
    tick(2);
    dmaReqPin = 1'b0;
    tick(4);
    chk("R8 device stop ack write", wrStbPin, 1);
    waitDone("R10 write b done");
    chk("R9 write crc even", ddOut, crcM);
    chk("R7 no pad when even", wrEdges, 8);
    tick(2);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule